// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block tracks up to 256 interrupt vectors for one processor. Each vector has three state bits: requested, in service, and level-triggered. The larger the vector number, the higher its priority. The upper four bits of a vector form its priority class. A task priority register (TPR) and the highest in-service vector together set a processor priority value (PPR). The block raises `irq_pending` when the best waiting request belongs to a class above that priority.

The processor uses three strobes. `ack_req` takes the winning request and moves it into service. `eoi` retires the highest in-service vector. `set_valid` posts a new request from any source. The TPR and the spurious-vector register are written through two simple write strobes. The spurious-vector register holds the software enable bit and the vector that is returned when an acknowledge is refused.

All priority searches are combinational over the full 256-bit vectors. State changes at the clock edge that samples a strobe. `irq_pending` and `ppr` follow the new state in the same cycle. `ack_vector`, `ack_level` and `new_count` are registered and show the result after that edge.

Top module: `vec_irq_prio`

## Requirements
- R1: After reset, `irq_pending` is 0, `ppr` is 0x00, `new_count` is 0 and `ack_vector` is 0x00. Internally the TPR is 0, the spurious register is 0x0FF (enable bit 8 clear, vector 0xFF), and the request, in-service and trigger vectors are all clear.
- R2: Among the set request bits, the one with the highest vector number wins an acknowledge.
- R3: Let C be the class of the highest in-service vector, or 0 when nothing is in service. If TPR[7:4] is at least C, `ppr` equals the TPR. Otherwise `ppr` equals {C, 4'h0}.
- R4: `irq_pending` is 1 only when all three hold: enable bit 8 is set, at least one request exists, and either `ppr` is 0 or the top request's class is strictly greater than `ppr[7:4]`.
- R5: `set_valid` sets the request bit of `set_vector`. It also records `set_level` as that vector's trigger mode (1 = level, 0 = edge). When the vector is later acknowledged, `ack_level` reports the trigger mode recorded by the most recent set.
- R6: An acknowledge is refused when any of the following holds: the enable bit is clear, there are no requests, or the TPR is nonzero and the top request is at most the TPR (a full 8-bit compare). A refused acknowledge returns the spurious register's low 8 bits on `ack_vector`, returns 0 on `ack_level`, and changes no bit vector.
- R7: A granted acknowledge clears the top request bit and sets the same bit in service. The vector number appears on `ack_vector` after that clock edge.
- R8: `eoi` clears only the highest set in-service bit. With nothing in service it has no effect.
- R9: A write to the spurious register keeps bits [8:0] of `spur_wdata` and ignores the bits above them.
- R10: `new_count` increments on a set only if that vector's request bit was clear beforehand. A repeated set of an already-requested vector does not change it.
- R11: When `eoi` and `ack_req` arrive in the same cycle, the end of interrupt takes effect first. When `set_valid` arrives in the same cycle as a granted acknowledge of the same vector, the request bit ends up set.
- R12: A TPR write changes `ppr` and `irq_pending` from the cycle after the write edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_valid | input | 1 | Post a request for `set_vector` |
| set_vector | input | 8 | Vector to request |
| set_level | input | 1 | Trigger mode of the request: 1 = level, 0 = edge |
| ack_req | input | 1 | Acknowledge strobe |
| eoi | input | 1 | End-of-interrupt strobe |
| tpr_we | input | 1 | Task priority write strobe |
| tpr_wdata | input | 8 | Task priority write data |
| spur_we | input | 1 | Spurious register write strobe |
| spur_wdata | input | 16 | Spurious register write data; bits [8:0] are kept |
| irq_pending | output | 1 | A request beats the processor priority |
| ack_vector | output | 8 | Vector returned by the last acknowledge |
| ack_level | output | 1 | Trigger mode of the last granted vector |
| ppr | output | 8 | Processor priority value |
| new_count | output | 16 | Count of newly delivered requests |

## Verification
Requests are posted in scrambled order across several classes. The order of acknowledges then shows that selection is by highest vector number. A mix of edge and level sets shows that the trigger mode follows the most recent set.

Several cases sit exactly on a threshold:
- A TPR equal to the request separates the full-vector compare used by acknowledge.
- A request in the same class as the in-service vector separates the strict class compare used by pending.

Simultaneous strobes check the stated ordering. A pair of spurious-register writes, one with the enable bit hidden above bit 8, shows that truncation and the disabled path behave independently.

// File: rtl/vec_irq_prio.sv
module vec_irq_prio #(
  parameter int VW = 8,
  parameter int CW = 16,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_valid,
  input  logic [VW-1:0] set_vector,
  input  logic          set_level,
  input  logic          ack_req,
  input  logic          eoi,
  input  logic          tpr_we,
  input  logic [VW-1:0] tpr_wdata,
  input  logic          spur_we,
  input  logic [SW-1:0] spur_wdata,
  output logic          irq_pending,
  output logic [VW-1:0] ack_vector,
  output logic          ack_level,
  output logic [VW-1:0] ppr,
  output logic [CW-1:0] new_count
);
  localparam int NV = 1 << VW;
  localparam int CB = VW - 4;

  logic [NV-1:0] irr_q, isr_q, tmr_q;
  logic [VW-1:0] tpr_q;
  logic [VW:0]   spur_q;

  function automatic logic [VW-1:0] top_bit(input logic [NV-1:0] v);
    top_bit = '0;
    for (int i = 0; i < NV; i++)
      if (v[i]) top_bit = i[VW-1:0];
  endfunction

  logic          irr_any, isr_any, spur_en, ack_spur, ack_grant;
  logic [VW-1:0] irr_top, isr_top;
  logic [CB-1:0] isr_cls;
  logic [NV-1:0] grant_bit, eoi_bit, set_bit;

  assign irr_any = |irr_q;
  assign isr_any = |isr_q;
  assign irr_top = top_bit(irr_q);
  assign isr_top = top_bit(isr_q);
  assign spur_en = spur_q[VW];
  assign isr_cls = isr_any ? isr_top[VW-1:4] : '0;

  assign ppr = (tpr_q[VW-1:4] >= isr_cls) ? tpr_q : {isr_cls, 4'h0};

  assign irq_pending = spur_en && irr_any &&
                       ((ppr == '0) || (irr_top[VW-1:4] > ppr[VW-1:4]));

  assign ack_spur  = !spur_en || !irr_any || ((tpr_q != '0) && (irr_top <= tpr_q));
  assign ack_grant = ack_req && !ack_spur;

  assign grant_bit = ack_grant ? (NV'(1) << irr_top) : '0;
  assign eoi_bit   = (eoi && isr_any) ? (NV'(1) << isr_top) : '0;
  assign set_bit   = set_valid ? (NV'(1) << set_vector) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr_q      <= '0;
      isr_q      <= '0;
      tmr_q      <= '0;
      tpr_q      <= '0;
      spur_q     <= {1'b0, {VW{1'b1}}};
      ack_vector <= '0;
      ack_level  <= 1'b0;
      new_count  <= '0;
    end else begin
      irr_q <= (irr_q & ~grant_bit) | set_bit;
      isr_q <= (isr_q & ~eoi_bit) | grant_bit;
      if (set_valid) begin
        tmr_q[set_vector] <= set_level;
        if (!irr_q[set_vector]) new_count <= new_count + 1'b1;
      end
      if (tpr_we)  tpr_q  <= tpr_wdata;
      if (spur_we) spur_q <= spur_wdata[VW:0];
      if (ack_req) begin
        ack_vector <= ack_grant ? irr_top : spur_q[VW-1:0];
        ack_level  <= ack_grant ? tmr_q[irr_top] : 1'b0;
      end
    end
  end
endmodule

// File: rtl/vec_irq_prio_chk.sv
module vec_irq_prio_chk #(
  parameter int VW = 8,
  parameter int CW = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 set_valid,
  input logic [VW-1:0]        set_vector,
  input logic                 ack_req,
  input logic                 eoi,
  input logic                 irq_pending,
  input logic [VW-1:0]        ppr,
  input logic [CW-1:0]        new_count,
  input logic [(1<<VW)-1:0]   irr,
  input logic [(1<<VW)-1:0]   isr,
  input logic [VW-1:0]        tpr,
  input logic                 spur_en
);
  a_r4_pending_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending |-> spur_en);

  a_r3_ppr_not_below_tpr: assert property (@(posedge clk) disable iff (!rst_n)
    ppr[VW-1:4] >= tpr[VW-1:4]);

  a_r5_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    set_valid |=> irr[$past(set_vector)]);

  a_r8_eoi_clears_one: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !ack_req && (isr != '0)) |=> ($countones(isr) == $past($countones(isr)) - 1));

  a_r6_disabled_ack_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && !spur_en && !set_valid && !eoi) |=> ($stable(irr) && $stable(isr)));

  a_r10_count_needs_set: assert property (@(posedge clk) disable iff (!rst_n)
    !set_valid |=> $stable(new_count));
endmodule

bind vec_irq_prio vec_irq_prio_chk #(.VW(VW), .CW(CW)) chk (
  .clk(clk), .rst_n(rst_n), .set_valid(set_valid), .set_vector(set_vector),
  .ack_req(ack_req), .eoi(eoi), .irq_pending(irq_pending), .ppr(ppr),
  .new_count(new_count), .irr(irr_q), .isr(isr_q), .tpr(tpr_q), .spur_en(spur_q[VW])
);

// File: tb/vec_irq_prio_test.sv
module vec_irq_prio_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        set_valid = 0, set_level = 0, ack_req = 0, eoi = 0, tpr_we = 0, spur_we = 0;
  logic [7:0]  set_vector = 0, tpr_wdata = 0;
  logic [15:0] spur_wdata = 0;
  logic        irq_pending, ack_level;
  logic [7:0]  ack_vector, ppr;
  logic [15:0] new_count;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  vec_irq_prio uut (
    .clk(clk), .rst_n(rst_n), .set_valid(set_valid), .set_vector(set_vector),
    .set_level(set_level), .ack_req(ack_req), .eoi(eoi), .tpr_we(tpr_we),
    .tpr_wdata(tpr_wdata), .spur_we(spur_we), .spur_wdata(spur_wdata),
    .irq_pending(irq_pending), .ack_vector(ack_vector), .ack_level(ack_level),
    .ppr(ppr), .new_count(new_count)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_cycle();
    @(negedge clk);
    set_valid = 0; ack_req = 0; eoi = 0; tpr_we = 0; spur_we = 0;
  endtask

  task automatic do_set(input logic [7:0] v, input logic lvl);
    @(negedge clk); set_valid = 1; set_vector = v; set_level = lvl; finish_cycle();
  endtask
  task automatic do_ack();
    @(negedge clk); ack_req = 1; finish_cycle();
  endtask
  task automatic do_eoi();
    @(negedge clk); eoi = 1; finish_cycle();
  endtask
  task automatic wr_tpr(input logic [7:0] d);
    @(negedge clk); tpr_we = 1; tpr_wdata = d; finish_cycle();
  endtask
  task automatic wr_spur(input logic [15:0] d);
    @(negedge clk); spur_we = 1; spur_wdata = d; finish_cycle();
  endtask

  task automatic t_reset();
    chk("R1 pending", irq_pending, 0);
    chk("R1 ppr", ppr, 8'h00);
    chk("R1 count", new_count, 0);
    chk("R1 ack_vector", ack_vector, 8'h00);
    do_set(8'h90, 1'b0);
    chk("R1 R4 disabled after reset", irq_pending, 0);
    do_ack();
    chk("R1 R6 reset spurious vector", ack_vector, 8'hFF);
    wr_spur(16'h01FF);
    chk("R4 enabled pending", irq_pending, 1);
    do_ack();
    chk("R7 grant 0x90", ack_vector, 8'h90);
    do_eoi();
    chk("R8 cleanup ppr", ppr, 8'h00);
  endtask

  task automatic t_priority();
    do_set(8'h31, 1'b0); do_set(8'h85, 1'b1); do_set(8'h40, 1'b0);
    chk("R4 pending with ppr zero", irq_pending, 1);
    do_ack();
    chk("R2 highest wins", ack_vector, 8'h85);
    chk("R5 level recorded", ack_level, 1);
    chk("R3 ppr from isr", ppr, 8'h80);
    chk("R4 lower class blocked", irq_pending, 0);
    do_eoi();
    chk("R8 ppr after eoi", ppr, 8'h00);
    chk("R4 pending again", irq_pending, 1);
    do_ack();
    chk("R2 next 0x40", ack_vector, 8'h40);
    chk("R5 edge recorded", ack_level, 0);
    do_ack();
    chk("R7 grant 0x31", ack_vector, 8'h31);
    chk("R3 ppr highest isr", ppr, 8'h40);
    do_eoi();
    chk("R8 only highest cleared", ppr, 8'h30);
    do_eoi();
    do_eoi();
    chk("R8 empty eoi no effect", ppr, 8'h00);
    chk("R8 no pending", irq_pending, 0);
  endtask

  task automatic t_coalesce();
    int c0 = new_count;
    do_set(8'h50, 1'b1);
    do_set(8'h50, 1'b0);
    chk("R10 coalesced count", new_count, c0 + 1);
    do_set(8'h51, 1'b0);
    chk("R10 new vector counted", new_count, c0 + 2);
    do_ack();
    chk("R2 0x51 first", ack_vector, 8'h51);
    do_eoi();
  endtask

  task automatic t_tpr();
    @(negedge clk); tpr_we = 1; tpr_wdata = 8'h60;
    chk("R12 pending before tpr edge", irq_pending, 1);
    finish_cycle();
    chk("R12 pending after tpr write", irq_pending, 0);
    chk("R3 ppr equals tpr", ppr, 8'h60);
    do_ack();
    chk("R6 below tpr spurious", ack_vector, 8'hFF);
    chk("R6 spurious level", ack_level, 0);
    wr_tpr(8'h50);
    do_ack();
    chk("R6 equal tpr spurious", ack_vector, 8'hFF);
    wr_tpr(8'h4F);
    do_ack();
    chk("R6 R5 request kept and edge mode", ack_vector, 8'h50);
    chk("R5 last set edge", ack_level, 0);
    chk("R3 isr class beats tpr", ppr, 8'h50);
    do_set(8'h5A, 1'b0);
    chk("R4 same class blocked", irq_pending, 0);
    do_set(8'h60, 1'b0);
    chk("R4 higher class pending", irq_pending, 1);
    do_ack(); do_ack();
    chk("R2 0x5A after 0x60", ack_vector, 8'h5A);
    do_eoi(); do_eoi(); do_eoi();
    wr_tpr(8'h00);
    chk("R12 ppr zero", ppr, 8'h00);
  endtask

  task automatic t_same_cycle();
    do_set(8'h20, 1'b0); do_ack();
    do_set(8'h70, 1'b0);
    @(negedge clk); ack_req = 1; eoi = 1; finish_cycle();
    chk("R11 ack with eoi vector", ack_vector, 8'h70);
    chk("R11 eoi applied first", ppr, 8'h70);
    do_eoi();
    do_set(8'h33, 1'b0);
    @(negedge clk); ack_req = 1; set_valid = 1; set_vector = 8'h33; set_level = 1; finish_cycle();
    chk("R11 granted 0x33", ack_vector, 8'h33);
    chk("R11 blocked by own class", irq_pending, 0);
    do_eoi();
    chk("R11 request re-set", irq_pending, 1);
    do_ack();
    chk("R11 R5 reposted level", ack_level, 1);
    do_eoi();
  endtask

  task automatic t_spur();
    wr_spur(16'hFE3F);
    do_set(8'h90, 1'b0);
    chk("R9 upper bits ignored, disabled", irq_pending, 0);
    do_ack();
    chk("R9 R6 spurious low byte", ack_vector, 8'h3F);
    wr_spur(16'h01FF);
    chk("R6 request survived", irq_pending, 1);
    do_ack();
    chk("R7 grant 0x90", ack_vector, 8'h90);
    do_eoi();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_priority();
    t_coalesce();
    t_tpr();
    t_same_cycle();
    t_spur();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule